// File: doc/BRIEF.md
# Write-Protect and Power-Down Mode Controller

This block keeps the mode state of a serial nonvolatile store that also feeds a bank of DAC channels. It decodes one-cycle command strobes (read, write, write-enable, write-disable, power-down-request, power-down-release), together with the region and channel a command addresses. From these it produces the permissions for the rest of the device. It also takes three level inputs: a run pin (low forces power-down), a DAC unlock pin (low blocks every change that touches a DAC channel) and the chip-select level.

Its outputs fall into two groups. The per-command outputs are a commit pulse for the nonvolatile array, a one-hot channel-load vector and a flag that says whether a channel loads from the stored byte or from the command data. The mode outputs are DAC standby, per-channel output high-impedance, EEPROM standby and an encoded power mode.

The datapath around the block uses these outputs in the same cycle as the strobe. A DAC-region write with the unlock pin high always moves the live channel. The stored byte follows only when programming is enabled.

Top module: `mode_guard_ctl`

## Requirements
- R1: While `rst_n` is low, the programming-enable state and the requested power-down state are both cleared. With `run_pin` high and no strobes active, `pwr_mode` is 0 (normal) and all standby and high-impedance outputs are 0.
- R2: `cmd_wren` sets the programming-enable state at the clock edge and `cmd_wrds` clears it. When both strobes are active together, the state is cleared. Reads neither need nor change this state.
- R3: A write to the memory region (`tgt_dac`=0) raises `arr_we` in the strobe cycle exactly when programming is enabled, whatever the level of `dac_unlock`. It never drives `chan_upd`.
- R4: A DAC-region write (`tgt_dac`=1) with `dac_unlock` high and programming enabled raises `arr_we` and sets bit `tgt_ch` of `chan_upd`, with `upd_from_store`=0.
- R5: A DAC-region write with `dac_unlock` high and programming disabled sets bit `tgt_ch` of `chan_upd` with `upd_from_store`=0, while `arr_we` stays 0.
- R6: A DAC-region write with `dac_unlock` low leaves both `arr_we` and `chan_upd` at 0.
- R7: A DAC-region read sets bit `tgt_ch` of `chan_upd` with `upd_from_store`=1, whatever `dac_unlock` and the programming state. `arr_we` stays 0. A memory-region read drives none of these outputs.
- R8: While `run_pin` is low, `dac_sleep`=1 and every bit of `dac_hiz` is 1. Power-down request and release strobes have no effect: this shows as an unchanged mode once `run_pin` returns high.
- R9: With `run_pin` high, `cmd_pden` puts the block into power-down from the next cycle and `cmd_pdds` returns it to normal. Release wins when both are active.
- R10: `pwr_mode` is 0 when normal, 1 when powered down with `chip_sel` low (DAC standby only), and 2 when powered down with `chip_sel` high, in which case `ee_sleep`=1. This also holds during reset.
- R11: A requested power-down persists through an interval of `run_pin` low, including across a release strobe issued in that interval.
- R12: With no read or write strobe active, `arr_we`, `chan_upd` and `upd_from_store` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cmd_read | input | 1 | Decoded read strobe |
| cmd_write | input | 1 | Decoded write strobe |
| cmd_wren | input | 1 | Programming-enable strobe |
| cmd_wrds | input | 1 | Programming-disable strobe |
| cmd_pden | input | 1 | Power-down request strobe |
| cmd_pdds | input | 1 | Power-down release strobe |
| tgt_dac | input | 1 | 1 = command addresses the DAC register region, 0 = general memory |
| tgt_ch | input | CH_W | DAC channel addressed by the command |
| run_pin | input | 1 | Level input, low forces power-down |
| dac_unlock | input | 1 | Level input, low blocks DAC-region writes |
| chip_sel | input | 1 | Chip-select level (high = deselected) |
| arr_we | output | 1 | Commit the write to the nonvolatile array |
| chan_upd | output | NUM_CH | One-hot load strobe for the live channel outputs |
| upd_from_store | output | 1 | Channel load source: 1 = stored byte, 0 = command data |
| dac_sleep | output | 1 | DAC section standby |
| dac_hiz | output | NUM_CH | Per-channel analog output high impedance |
| ee_sleep | output | 1 | EEPROM section standby |
| pwr_mode | output | 2 | 0 normal, 1 shallow power-down, 2 deep power-down |

## Verification
The hardest situation to reach is a power-down request that lives through a forced interval. The request must be latched while the run pin is high. The run pin must then drop, a release strobe must be issued while the pin is low, and the pin must return high, at which point the block must still report power-down. The stimulus walks this path in order and then also releases the request normally. A second sequence aims at the other way a strobe can be ignored: a request strobe issued while the run pin is low must leave the block normal once the pin rises. A behavioural model in the bench predicts all outputs on every cycle, so each of these steps is compared directly.

// File: rtl/mode_guard_pkg.sv
package mode_guard_pkg;
   typedef enum logic [1:0] {
      PWR_NORMAL  = 2'd0,
      PWR_SHALLOW = 2'd1,
      PWR_DEEP    = 2'd2
   } pwr_mode_e;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/mg_prog_latch.sv
module mg_prog_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_wren,
   input  logic cmd_wrds,
   output logic prog_en
);
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en_q <= 1'b0;
      else if (cmd_wrds) en_q <= 1'b0;
      else if (cmd_wren) en_q <= 1'b1;
   end

   assign prog_en = en_q;

   // R2
   wren_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wren && !cmd_wrds) |=> prog_en);
   // R2
   wrds_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wrds |=> !prog_en);
endmodule

// File: rtl/mg_write_gate.sv
module mg_write_gate #(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned CH_W = mode_guard_pkg::sel_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_read,
   input  logic              cmd_write,
   input  logic              tgt_dac,
   input  logic [CH_W-1:0]   tgt_ch,
   input  logic              dac_unlock,
   input  logic              prog_en,
   output logic              arr_we,
   output logic [NUM_CH-1:0] chan_upd,
   output logic              upd_from_store
);
   logic mem_wr, dac_wr_ok, dac_rd, dac_hit;

   always_comb begin
      mem_wr    = cmd_write && !tgt_dac;
      dac_wr_ok = cmd_write && tgt_dac && dac_unlock;
      dac_rd    = cmd_read && tgt_dac;
      dac_hit   = dac_wr_ok || dac_rd;
      arr_we    = (mem_wr || dac_wr_ok) && prog_en;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      assign chan_upd[i] = dac_hit && (tgt_ch == CH_W'(i));
   end

   assign upd_from_store = dac_rd;

   // R6
   lock_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_write && tgt_dac && !dac_unlock) |-> (chan_upd == '0 && !arr_we));
   // R7
   read_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_read && !cmd_write) |-> !arr_we);
   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_read && !cmd_write) |-> (chan_upd == '0 && !arr_we && !upd_from_store));
   // R4
   upd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_upd));
endmodule

// File: rtl/mg_power_ctl.sv
module mg_power_ctl #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_pden,
   input  logic              cmd_pdds,
   input  logic              run_pin,
   input  logic              chip_sel,
   output logic              dac_sleep,
   output logic [NUM_CH-1:0] dac_hiz,
   output logic              ee_sleep,
   output logic [1:0]        pwr_mode
);
   import mode_guard_pkg::*;

   logic req_q, down;
   pwr_mode_e mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    req_q <= 1'b0;
      else if (run_pin && cmd_pdds)  req_q <= 1'b0;
      else if (run_pin && cmd_pden)  req_q <= 1'b1;
   end

   always_comb begin
      down = !run_pin || req_q;
      if (!down)         mode = PWR_NORMAL;
      else if (chip_sel) mode = PWR_DEEP;
      else               mode = PWR_SHALLOW;
   end

   assign dac_sleep = down;
   assign dac_hiz   = {NUM_CH{down}};
   assign ee_sleep  = (mode == PWR_DEEP);
   assign pwr_mode  = mode;

   // R8
   pin_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_pin |-> (dac_sleep && (&dac_hiz)));
   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_pin |=> $stable(req_q));
   // R9
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_pin && cmd_pdds) |=> (run_pin |-> !dac_sleep));
   // R10
   deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sleep |-> (dac_sleep && chip_sel));
endmodule

// File: rtl/mode_guard_ctl.sv
module mode_guard_ctl #(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned CH_W = mode_guard_pkg::sel_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_read,
   input  logic              cmd_write,
   input  logic              cmd_wren,
   input  logic              cmd_wrds,
   input  logic              cmd_pden,
   input  logic              cmd_pdds,
   input  logic              tgt_dac,
   input  logic [CH_W-1:0]   tgt_ch,
   input  logic              run_pin,
   input  logic              dac_unlock,
   input  logic              chip_sel,
   output logic              arr_we,
   output logic [NUM_CH-1:0] chan_upd,
   output logic              upd_from_store,
   output logic              dac_sleep,
   output logic [NUM_CH-1:0] dac_hiz,
   output logic              ee_sleep,
   output logic [1:0]        pwr_mode
);
   if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_cfg
      $error("mode_guard_ctl: NUM_CH must be in 1..64");
   end

   logic prog_en;

   mg_prog_latch i_latch (
      .clk(clk), .rst_n(rst_n),
      .cmd_wren(cmd_wren), .cmd_wrds(cmd_wrds),
      .prog_en(prog_en)
   );

   mg_write_gate #(.NUM_CH(NUM_CH)) i_gate (
      .clk(clk), .rst_n(rst_n),
      .cmd_read(cmd_read), .cmd_write(cmd_write),
      .tgt_dac(tgt_dac), .tgt_ch(tgt_ch),
      .dac_unlock(dac_unlock), .prog_en(prog_en),
      .arr_we(arr_we), .chan_upd(chan_upd),
      .upd_from_store(upd_from_store)
   );

   mg_power_ctl #(.NUM_CH(NUM_CH)) i_pwr (
      .clk(clk), .rst_n(rst_n),
      .cmd_pden(cmd_pden), .cmd_pdds(cmd_pdds),
      .run_pin(run_pin), .chip_sel(chip_sel),
      .dac_sleep(dac_sleep), .dac_hiz(dac_hiz),
      .ee_sleep(ee_sleep), .pwr_mode(pwr_mode)
   );

   // R3
   mem_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wren && !cmd_wrds) ##1 (cmd_write && !tgt_dac && !cmd_wrds) |-> arr_we);
endmodule

// File: tb/test_mode_guard_ctl.sv
`timescale 1ns/1ps
module test_mode_guard_ctl;
   localparam int NUM_CH = 4;
   localparam int CH_W = 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, cmd_read, cmd_write, cmd_wren, cmd_wrds, cmd_pden, cmd_pdds;
   logic tgt_dac, run_pin, dac_unlock, chip_sel;
   logic [CH_W-1:0] tgt_ch;
   logic arr_we, upd_from_store, dac_sleep, ee_sleep;
   logic [NUM_CH-1:0] chan_upd, dac_hiz;
   logic [1:0] pwr_mode;

   mode_guard_ctl #(.NUM_CH(NUM_CH)) i_mode_guard_ctl (.*);

   // pending stimulus applied just after each rising edge
   logic n_rst, n_rd, n_wr, n_wren, n_wrds, n_pden, n_pdds, n_dac, n_run, n_unl, n_sel;
   int   n_ch;
   int   m_prog, m_req;
   int   tests = 0, fails = 0;
   bit   done = 0;

   task automatic idle_cmds();
      n_rd = 0; n_wr = 0; n_wren = 0; n_wrds = 0; n_pden = 0; n_pdds = 0;
   endtask

   task automatic apply();
      rst_n = n_rst; cmd_read = n_rd; cmd_write = n_wr; cmd_wren = n_wren;
      cmd_wrds = n_wrds; cmd_pden = n_pden; cmd_pdds = n_pdds; tgt_dac = n_dac;
      tgt_ch = CH_W'(n_ch); run_pin = n_run; dac_unlock = n_unl; chip_sel = n_sel;
   endtask

   task automatic compare(input string tag);
      int e_we, e_upd, e_src, e_down, e_mode;
      logic [4+2*NUM_CH+1:0] exp_v, act_v;
      e_we  = cmd_write && (!tgt_dac || dac_unlock) && m_prog != 0;
      e_upd = ((cmd_write && tgt_dac && dac_unlock) || (cmd_read && tgt_dac)) ? (1 << tgt_ch) : 0;
      e_src = cmd_read && tgt_dac;
      e_down = !run_pin || m_req != 0;
      e_mode = !e_down ? 0 : (chip_sel ? 2 : 1);
      exp_v = {1'(e_we), NUM_CH'(e_upd), 1'(e_src), 1'(e_down),
               {NUM_CH{1'(e_down)}}, 1'(e_mode == 2), 2'(e_mode)};
      act_v = {arr_we, chan_upd, upd_from_store, dac_sleep, dac_hiz, ee_sleep, pwr_mode};
      tests++;
      if (act_v !== exp_v) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", tag, act_v, exp_v);
      end
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      if (!rst_n) begin
         m_prog = 0; m_req = 0;
      end else begin
         if (cmd_wrds) m_prog = 0; else if (cmd_wren) m_prog = 1;
         if (run_pin) begin
            if (cmd_pdds) m_req = 0; else if (cmd_pden) m_req = 1;
         end
      end
      #1 apply();
      if (!rst_n) begin m_prog = 0; m_req = 0; end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      idle_cmds(); n_rst = 0; n_dac = 0; n_ch = 0; n_run = 0; n_unl = 1; n_sel = 1;
      m_prog = 0; m_req = 0;
      apply();
      @(negedge clk); compare("R10 deep mode in reset");
      n_sel = 0; tick("R10 shallow mode in reset");
      n_run = 1; tick("R1 reset state");
      n_rst = 1; tick("R1 after release");
      // memory write with latch clear, unlock low too
      n_wr = 1; n_unl = 0; tick("R3 mem write latch clear");
      idle_cmds(); n_wren = 1; tick("R2 wren");
      idle_cmds(); n_wr = 1; tick("R3 mem write unlock low");
      n_unl = 1; tick("R3 mem write unlock high");
      n_dac = 1; n_ch = 2; tick("R4 dac write latch set");
      n_ch = 3; n_unl = 0; tick("R6 dac write locked");
      n_unl = 1; n_ch = 0; tick("R4 dac write ch0");
      idle_cmds(); n_wren = 1; n_wrds = 1; tick("R2 wren with wrds");
      idle_cmds(); n_wr = 1; n_dac = 0; tick("R2 mem write after both");
      n_dac = 1; n_ch = 3; tick("R5 dac write latch clear");
      n_unl = 0; tick("R6 dac write locked latch clear");
      idle_cmds(); n_rd = 1; n_ch = 1; tick("R7 dac read locked");
      n_dac = 0; tick("R7 mem read");
      idle_cmds(); n_unl = 1; tick("R12 idle");
      n_pden = 1; tick("R9 pden");
      idle_cmds(); tick("R9 held down");
      n_sel = 1; tick("R10 deep");
      n_rd = 1; n_dac = 1; n_ch = 2; tick("R7 read while down");
      idle_cmds(); n_sel = 0; n_pdds = 1; tick("R9 pdds");
      idle_cmds(); tick("R9 normal again");
      n_pden = 1; n_pdds = 1; tick("R9 both strobes");
      idle_cmds(); tick("R9 release wins");
      n_run = 0; tick("R8 pin low");
      n_pden = 1; tick("R8 pden ignored");
      idle_cmds(); n_sel = 1; tick("R8 pin low deep");
      n_sel = 0; n_run = 1; tick("R8 still normal");
      n_pden = 1; tick("R11 request");
      idle_cmds(); n_run = 0; tick("R11 pin low");
      n_pdds = 1; tick("R11 pdds ignored");
      idle_cmds(); n_run = 1; tick("R11 persists");
      tick("R11 persists 2");
      n_pdds = 1; tick("R11 release");
      idle_cmds(); tick("R11 normal");
      n_rst = 0; n_wren = 1; tick("R1 reset again");
      n_rst = 1; idle_cmds(); tick("R1 released");
      n_wr = 1; tick("R1 latch cleared");
      idle_cmds(); tick("R12 final idle");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule